// File: doc/BRIEF.md
# Firmware Mailbox Command Sequencer

This block is a bus master that runs one command at a time against a firmware mailbox. The mailbox has two registers: a 64-bit data register and a 32-bit interface register. Bit 31 of the interface register is a busy flag, and the command identifier sits in its low bits. A client hands the sequencer a request made of an opcode, a direction flag and 32 bits of write data. The sequencer then runs the fixed access sequence over a simple request/acknowledge register port. When the sequence ends, it returns a status and, for reads, the response word.

Every command starts and ends with a bounded wait for the busy flag to clear. A write command stores its data before it issues the command word. A read command fetches the data register after the second wait. One opcode, the short-read opcode, returns only the low 32 bits of the data register. If the busy flag is still set after the last allowed poll, the command stops on the spot with a timeout status and makes no further bus access.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, and `done` and `bus_req` are 0.
- R2: A write command makes these accesses in order: interface-register reads at byte address 0x5818 until one returns bit 31 clear; a write of `{32'h0, req_wdata}` to the data register at 0x5810; a write to 0x5818 of a word with bit 31 set, the opcode in bits 15:0 and all other bits zero; then more interface-register reads until bit 31 reads clear.
- R3: A read command makes these accesses in order: interface-register polling, the command-word write (same format as R2), more polling, and one read of the data register at 0x5810. The value read is returned on `rsp_data`.
- R4: While a poll returns bit 31 set, the sequencer issues another interface-register read. A bus request keeps its address and direction until it is acknowledged.
- R5: A single wait makes at most 100 interface-register reads. If the 100th read still shows busy, the command ends with `done_status` = 1 and `rsp_data` = 0, and no further bus access follows. This applies to the wait before the command and to the wait after it.
- R6: A read with opcode 0x0018 (the short-read opcode) returns the low 32 bits of the data register, with bits 63:32 of `rsp_data` forced to zero.
- R7: A read with any other opcode returns all 64 bits of the data register.
- R8: `req_ready` is low from the cycle after a request is accepted until the command completes. `done` is a single-cycle pulse, carrying `done_status` = 0 on success. For write commands `rsp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client offers a command |
| req_ready | output | 1 | Sequencer is idle and will take a command |
| req_write | input | 1 | 1 = write command, 0 = read command |
| req_op | input | 16 | Command opcode |
| req_wdata | input | 32 | Data for a write command |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 1 | 0 = success, 1 = busy timeout |
| rsp_data | output | 64 | Response word, valid with `done` |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_addr | output | 16 | Byte address of the access |
| bus_we | output | 1 | 1 = write access |
| bus_wdata | output | 64 | Write data (32-bit values in the low lane) |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |

## Verification
If the sequencer state is corrupted, it shows up at the bus port within the next access. A poll that is skipped, or an access made out of turn, changes the address or direction seen by the responder model. A count that is too short or too long shows up in the number of accesses, which is compared against the preset busy-read count of each wait. Errors in the response path or the status path show up at the `done` pulse itself, as a wrong upper half, a wrong status bit or a stale response word. A bus access after a timeout shows up as an access count that keeps growing once `done` has fired.

// File: rtl/mbox_pkg.sv
// Package: shared state encoding and status codes for the mailbox sequencer.
// Assumes: one master, one command in flight.
package mbox_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_POLL_PRE,
        SQ_WR_DATA,
        SQ_WR_CMD,
        SQ_POLL_POST,
        SQ_RD_DATA,
        SQ_FINISH
    } sq_state_e;

    localparam logic STAT_OK      = 1'b0;
    localparam logic STAT_TIMEOUT = 1'b1;

endpackage

// File: rtl/mbox_poll_ctr.sv
// Module: counts busy readings within one ready-wait and flags the final
// allowed attempt. Assumes: clear and bump are never requested together.
module mbox_poll_ctr #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Attempt counter: cleared between waits, incremented on each busy reading.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (bump)     cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CNT_W'(LIMIT - 1));

    // The counter never reaches the limit: the final busy reading ends the wait.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/mbox_rsp_fmt.sv
// Module: selects the response width from the opcode. The short-read opcode
// keeps only the low 32 bits. Assumes: raw holds the data register value.
module mbox_rsp_fmt #(
    parameter int              OP_W     = 16,
    parameter logic [OP_W-1:0] SHORT_OP = 16'h0018
) (
    input  logic [OP_W-1:0] op,
    input  logic [63:0]     raw,
    output logic [63:0]     rsp
);
    // Width selection: zero the upper half for the short opcode only.
    always_comb begin
        rsp = raw;
        if (op == SHORT_OP) rsp[63:32] = '0;
    end
endmodule

// File: rtl/mbox_cmd_engine.sv
// Module: mailbox command sequencer. Runs ready-wait, optional data write,
// command write, ready-wait and optional data read over a request/ack port.
// Assumes: one outstanding access; bus_rdata is valid with bus_ack.
module mbox_cmd_engine
    import mbox_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                OP_W       = 16,
    parameter logic [ADDR_W-1:0] DATA_OFS   = 16'h5810,
    parameter logic [ADDR_W-1:0] IFACE_OFS  = 16'h5818,
    parameter int                BUSY_POS   = 31,
    parameter int                POLL_LIMIT = 100,
    parameter logic [OP_W-1:0]   SHORT_OP   = 16'h0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OP_W-1:0]   req_op,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic              done_status,
    output logic [63:0]       rsp_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [63:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [63:0]       bus_rdata
);
    sq_state_e       state, state_nx;
    logic            wr_q;
    logic [OP_W-1:0] op_q;
    logic [31:0]     wd_q;
    logic            poll_st, busy_seen, poll_last, poll_clr, poll_bump;
    logic [63:0]     cmd_word, rsp_fmt;
    logic            accept;

    assign accept    = req_valid && req_ready;
    assign req_ready = (state == SQ_IDLE);
    assign done      = (state == SQ_FINISH);
    assign poll_st   = (state == SQ_POLL_PRE) || (state == SQ_POLL_POST);
    assign busy_seen = bus_rdata[BUSY_POS];
    assign poll_clr  = (state == SQ_IDLE) || (state == SQ_WR_CMD);
    assign poll_bump = poll_st && bus_ack && busy_seen && !poll_last;

    // Command word: busy flag plus opcode, all other bits zero.
    always_comb begin
        cmd_word = '0;
        cmd_word[BUSY_POS] = 1'b1;
        cmd_word[OP_W-1:0] = op_q;
    end

    mbox_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (poll_clr),
        .bump (poll_bump),
        .last (poll_last)
    );

    mbox_rsp_fmt #(.OP_W(OP_W), .SHORT_OP(SHORT_OP)) u_fmt (
        .op (op_q),
        .raw(bus_rdata),
        .rsp(rsp_fmt)
    );

    // Bus drive: address, direction and data for the current step.
    always_comb begin
        bus_req   = 1'b0;
        bus_addr  = IFACE_OFS;
        bus_we    = 1'b0;
        bus_wdata = '0;
        unique case (state)
            SQ_POLL_PRE, SQ_POLL_POST: bus_req = 1'b1;
            SQ_WR_DATA: begin
                bus_req   = 1'b1;
                bus_addr  = DATA_OFS;
                bus_we    = 1'b1;
                bus_wdata = {32'h0, wd_q};
            end
            SQ_WR_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = cmd_word;
            end
            SQ_RD_DATA: begin
                bus_req  = 1'b1;
                bus_addr = DATA_OFS;
            end
            default: ;
        endcase
    end

    // Next-state: advance on each acknowledged access, stop on timeout.
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:      if (accept) state_nx = SQ_POLL_PRE;
            SQ_POLL_PRE:  if (bus_ack) begin
                              if (!busy_seen)     state_nx = wr_q ? SQ_WR_DATA : SQ_WR_CMD;
                              else if (poll_last) state_nx = SQ_FINISH;
                          end
            SQ_WR_DATA:   if (bus_ack) state_nx = SQ_WR_CMD;
            SQ_WR_CMD:    if (bus_ack) state_nx = SQ_POLL_POST;
            SQ_POLL_POST: if (bus_ack) begin
                              if (!busy_seen)     state_nx = wr_q ? SQ_FINISH : SQ_RD_DATA;
                              else if (poll_last) state_nx = SQ_FINISH;
                          end
            SQ_RD_DATA:   if (bus_ack) state_nx = SQ_FINISH;
            default:      state_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            op_q <= '0;
            wd_q <= '0;
        end else if (accept) begin
            wr_q <= req_write;
            op_q <= req_op;
            wd_q <= req_wdata;
        end
    end

    // Result registers: cleared on acceptance, set by timeout or data read.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            done_status <= STAT_OK;
            rsp_data    <= '0;
        end else if (poll_st && bus_ack && busy_seen && poll_last) begin
            done_status <= STAT_TIMEOUT;
        end else if (state == SQ_RD_DATA && bus_ack) begin
            rsp_data <= rsp_fmt;
        end
    end

    // R1: reset leaves the sequencer idle with the bus quiet.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> req_ready && !done && !bus_req);

    // R2: every interface-register write carries the busy flag.
    p_busy_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == IFACE_OFS |-> bus_wdata[BUSY_POS]);

    // R4: an unacknowledged request holds its address and direction.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R5: a timeout returns a zero response and the bus goes quiet.
    p_timeout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_status |-> rsp_data == '0 && !bus_req);

    // R6: a short-opcode read never returns upper bits.
    p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !wr_q && op_q == SHORT_OP |-> rsp_data[63:32] == '0);

    // R8: done lasts exactly one cycle and is followed by readiness.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

endmodule

// File: tb/sim_mbox_cmd_engine.sv
`timescale 1ns/1ps
module sim_mbox_cmd_engine;

    localparam logic [15:0] DATA_A  = 16'h5810;
    localparam logic [15:0] IFACE_A = 16'h5818;

    typedef struct packed {
        logic        wr;
        logic [15:0] op;
        logic [31:0] wd;
        logic [7:0]  pre;
        logic [7:0]  post;
        logic [63:0] dreg;
        logic        st;
        logic [63:0] rsp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h001F, 32'hA5A5_1234, 8'd0,   8'd0,   64'h0,                    1'b0, 64'h0},
        '{1'b0, 16'h001E, 32'h0,         8'd2,   8'd3,   64'h1122_3344_5566_7788,  1'b0, 64'h1122_3344_5566_7788},
        '{1'b0, 16'h0018, 32'h0,         8'd0,   8'd1,   64'hDEAD_BEEF_CAFE_F00D,  1'b0, 64'h0000_0000_CAFE_F00D},
        '{1'b1, 16'h0042, 32'h0BAD_F00D, 8'd99,  8'd0,   64'h0,                    1'b0, 64'h0},
        '{1'b0, 16'h0007, 32'h0,         8'd100, 8'd0,   64'hFFFF_FFFF_FFFF_FFFF,  1'b1, 64'h0},
        '{1'b0, 16'h001E, 32'h0,         8'd0,   8'd100, 64'h0123_4567_89AB_CDEF,  1'b1, 64'h0},
        '{1'b1, 16'h0031, 32'h1357_9BDF, 8'd0,   8'd100, 64'h0,                    1'b1, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_op = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done, done_status;
    logic [63:0] rsp_data;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = '0;

    int tests = 0, fails = 0, cycles = 0;

    // Responder configuration and access log.
    int          cfg_pre = 0, cfg_post = 0;
    logic [63:0] cfg_dreg = '0;
    int          busy_left = 0, post_ld = 0, nacc = 0;
    logic [63:0] dreg = '0;
    logic [15:0] log_addr [0:255];
    logic        log_we   [0:255];
    logic [63:0] log_wd   [0:255];

    always #2 clk = ~clk;

    mbox_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_op(req_op), .req_wdata(req_wdata),
        .done(done), .done_status(done_status), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // Mailbox model: acks one cycle after a request, busy for a preset count.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            bus_ack <= 1'b0;
        end else if (req_valid && req_ready) begin
            busy_left <= cfg_pre;
            post_ld   <= cfg_post;
            dreg      <= cfg_dreg;
            nacc      <= 0;
            bus_ack   <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (nacc < 256) begin
                log_addr[nacc] <= bus_addr;
                log_we[nacc]   <= bus_we;
                log_wd[nacc]   <= bus_wdata;
            end
            nacc <= nacc + 1;
            bus_rdata <= '0;
            if (!bus_we && bus_addr == IFACE_A) begin
                if (busy_left > 0) begin
                    bus_rdata <= 64'h0000_0000_8000_0000;
                    busy_left <= busy_left - 1;
                end
            end else if (!bus_we && bus_addr == DATA_A) begin
                bus_rdata <= dreg;
            end else if (bus_we && bus_addr == IFACE_A) begin
                busy_left <= post_ld;
            end else if (bus_we && bus_addr == DATA_A) begin
                dreg <= bus_wdata;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Issue one command and wait at negedges for done.
    task automatic issue(input logic wr, input logic [15:0] op, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_op = op; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
        while (!done) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cycles > 60000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<60000", cycles);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0,      "R1 done",      64'(done),      64'd0);
        chk(bus_req == 1'b0,   "R1 bus_req",   64'(bus_req),   64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int pp, qp, exp_n, base;
            cfg_pre = int'(v.pre); cfg_post = int'(v.post); cfg_dreg = v.dreg;
            issue(v.wr, v.op, v.wd);
            // Expected access count from the preset busy readings (R2, R3, R5).
            pp = (v.pre >= 100) ? 100 : int'(v.pre) + 1;
            qp = (v.post >= 100) ? 100 : int'(v.post) + 1;
            if (v.pre >= 100) exp_n = 100;
            else exp_n = pp + (v.wr ? 2 : 1) + qp + ((!v.wr && v.post < 100) ? 1 : 0);
            chk(done_status == v.st, "R5/R8 status", 64'(done_status), 64'(v.st));
            chk(rsp_data == v.rsp, v.op == 16'h0018 ? "R6 short response" : "R7 response",
                rsp_data, v.rsp);
            chk(nacc == exp_n, "R4/R5 access count", 64'(nacc), 64'(exp_n));
            if (v.pre < 100) begin
                base = pp;
                if (v.wr) begin
                    chk(log_addr[base] == DATA_A && log_we[base], "R2 data write addr",
                        64'(log_addr[base]), 64'(DATA_A));
                    chk(log_wd[base] == {32'h0, v.wd}, "R2 data value", log_wd[base], {32'h0, v.wd});
                    base = base + 1;
                end
                chk(log_addr[base] == IFACE_A && log_we[base], v.wr ? "R2 cmd addr" : "R3 cmd addr",
                    64'(log_addr[base]), 64'(IFACE_A));
                chk(log_wd[base] == {32'h0, 1'b1, 15'h0, v.op}, v.wr ? "R2 cmd word" : "R3 cmd word",
                    log_wd[base], {32'h0, 1'b1, 15'h0, v.op});
                if (!v.wr && v.post < 100)
                    chk(log_addr[exp_n-1] == DATA_A && !log_we[exp_n-1], "R3 final data read",
                        64'(log_addr[exp_n-1]), 64'(DATA_A));
            end
            @(negedge clk);
            chk(done == 1'b0 && req_ready == 1'b1, "R8 done one-cycle pulse", 64'(done), 64'd0);
            if (v.st) begin
                repeat (8) @(negedge clk);
                chk(nacc == exp_n, "R5 no access after timeout", 64'(nacc), 64'(exp_n));
            end
        end

        // R4: a long pre-wait still ends on the first clear reading.
        cfg_pre = 50; cfg_post = 0; cfg_dreg = 64'hAAAA_5555_0F0F_F0F0;
        issue(1'b0, 16'h0055, 32'h0);
        chk(nacc == 51 + 1 + 1 + 1, "R4 fifty busy reads", 64'(nacc), 64'd54);
        chk(rsp_data == 64'hAAAA_5555_0F0F_F0F0, "R7 full width", rsp_data, 64'hAAAA_5555_0F0F_F0F0);

        // R1: reset in mid-command returns to idle.
        cfg_pre = 20; cfg_post = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_op = 16'h0001;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready == 1'b1 && bus_req == 1'b0, "R1 mid-command reset", 64'(bus_req), 64'd0);

        finish_run();
    end

endmodule